// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable synchronous static memory with a small, parameterised depth, built so that a shared data bus can carry reads and writes on back-to-back clocks with no idle cycle between them. Address and control are taken at a rising clock edge. A write's data is taken one or two edges later, in the same bus slot that a read issued on the same edge would use for its returned data. The host can therefore interleave reads and writes freely.

A static strap input, `pipe_mode`, picks the read timing. When it is low, the block runs in flow-through mode: read data leaves the array combinationally and write data follows its command by one edge. When it is high, the block runs in pipelined mode: an extra output register delays read data by one clock, and write data follows its command by two edges. Because of that delay, a pipelined read can name an address whose write data has not yet reached the array. The block forwards those pending bytes into the read result.

The bidirectional data bus is split into `d_in`, `d_out` and an enable, `d_oe`. Two further inputs act without waiting for a clock edge. An output-enable input forces the drivers off, and a sleep input forces them off and blocks new commands. Burst address generation is not part of this block.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted only when `sel_a_n` is 0, `sel_b_n` is 0 and `sel_c` is 1 at an enabled rising edge. Any other combination is a deselect and changes no memory location.
- R2: With `pipe_mode` = 0, a read accepted at edge T drives its data, with `d_oe` = 1, from just after edge T until edge T+1. A write accepted at edge T takes its data from `d_in` at the next enabled edge.
- R3: With `pipe_mode` = 1, a read accepted at edge T drives its data, with `d_oe` = 1, from just after edge T+1 until edge T+2. A write accepted at edge T takes its data from `d_in` at the second enabled edge after T.
- R4: The data word is made of 9-bit lanes, with lane k at bits [9k+8:9k]. A write changes lane k only when `lane_we_n[k]` was 0 at the write's command edge.
- R5: In pipelined mode, a read whose address matches a write still waiting for its data returns that write's enabled lanes from `d_in`, merged with the stored lanes.
- R6: Read, write and read commands may follow one another on consecutive edges, and each one completes correctly.
- R7: An edge at which `clk_en_n` is 1 is ignored. Pending reads, pending writes and the output state all hold.
- R8: `out_en_n` = 1 forces `d_oe` to 0 at once, without a clock edge. When it returns to 0, a valid read shows again.
- R9: `sleep` = 1 forces `d_oe` to 0 at once, and commands presented while it is 1 are ignored.
- R10: `d_oe` is 1 only during a read data slot. It is 0 in write data slots and after deselects.
- R11: While `rst_n` is 0, all pending reads and writes are cleared and `d_oe` is 0. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pending-operation state |
| clk_en_n | input | 1 | Active-low clock enable |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| wr_n | input | 1 | 0 = write command, 1 = read command |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| d_in | input | LANES*LANE_W | Write data from the bus |
| d_out | output | LANES*LANE_W | Read data to the bus |
| d_oe | output | 1 | Bus driver enable for `d_out` |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous power-down, active high |
| pipe_mode | input | 1 | Strap: 0 = flow-through, 1 = pipelined |

## Verification
The hardest case to reach from the ports is a pipelined read that names a word whose partial-lane write has been issued but whose data has not yet arrived. In that case the forwarded lanes and the stored lanes must be merged in the same edge that loads the output register. The stimulus reaches it in three steps on consecutive edges. First it issues a write to one lane. Next it issues a read of the same word. Then it issues a read of a second word while the late write data sits on `d_in`. A second scenario inserts a disabled clock between a write command and its data, which shows that the pending write waits rather than taking the wrong bus slot.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 4,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en_n,
  input  logic                      sel_a_n,
  input  logic                      sel_b_n,
  input  logic                      sel_c,
  input  logic                      wr_n,
  input  logic [LANES-1:0]          lane_we_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   d_in,
  output logic [LANES*LANE_W-1:0]   d_out,
  output logic                      d_oe,
  input  logic                      out_en_n,
  input  logic                      sleep,
  input  logic                      pipe_mode
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              wr_v1, wr_v2, rd_v1, rd_v2;
  logic [ADDR_W-1:0] wr_a1, wr_a2, rd_a1;
  logic [LANES-1:0]  wr_m1, wr_m2;
  logic [DATA_W-1:0] dout_q;

  wire adv    = ~clk_en_n;
  wire chosen = ~sel_a_n & ~sel_b_n & sel_c & ~sleep;
  wire rd_cmd = chosen & wr_n;
  wire wr_cmd = chosen & ~wr_n;

  wire              wr_go = pipe_mode ? wr_v2 : wr_v1;
  wire [ADDR_W-1:0] wr_ga = pipe_mode ? wr_a2 : wr_a1;
  wire [LANES-1:0]  wr_gm = pipe_mode ? wr_m2 : wr_m1;

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0]  en);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int k = 0; k < LANES; k++)
      if (en[k]) r[k*LANE_W +: LANE_W] = new_w[k*LANE_W +: LANE_W];
    return r;
  endfunction

  logic [DATA_W-1:0] array_q, fwd_q;
  assign array_q = mem[rd_a1];

  always_comb begin
    fwd_q = array_q;
    if (pipe_mode && wr_go && (wr_ga == rd_a1))
      fwd_q = lane_merge(array_q, d_in, wr_gm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_v1 <= 1'b0;
      wr_v2 <= 1'b0;
      rd_v1 <= 1'b0;
      rd_v2 <= 1'b0;
    end else if (adv) begin
      wr_v1 <= wr_cmd;
      wr_v2 <= wr_v1;
      rd_v1 <= rd_cmd;
      rd_v2 <= rd_v1;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      wr_a1  <= addr;
      wr_m1  <= ~lane_we_n;
      wr_a2  <= wr_a1;
      wr_m2  <= wr_m1;
      rd_a1  <= addr;
      dout_q <= fwd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && wr_go)
      mem[wr_ga] <= lane_merge(mem[wr_ga], d_in, wr_gm);
  end

  wire slot_valid = pipe_mode ? rd_v2 : rd_v1;
  assign d_oe  = slot_valid & ~out_en_n & ~sleep;
  assign d_out = pipe_mode ? dout_q : array_q;

  assert_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && (sel_a_n || sel_b_n || !sel_c)) |=> (!rd_v1 && !wr_v1));

  assert_pipe_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !clk_en_n && rd_v1) |=> rd_v2);

  assert_one_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_v1 && wr_v1));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> $stable({rd_v1, rd_v2, wr_v1, wr_v2}));

  assert_sleep_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !clk_en_n) |=> (!rd_v1 && !wr_v1));
endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
  localparam int AW = 4;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en_n = 1'b0;
  logic sel_a_n = 1'b1, sel_b_n = 1'b1, sel_c = 1'b0;
  logic wr_n = 1'b1;
  logic [LN-1:0] lane_we_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] d_in = '0;
  logic [DW-1:0] d_out;
  logic d_oe;
  logic out_en_n = 1'b0;
  logic sleep = 1'b0;
  logic pipe_mode = 1'b0;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  logic [DW-1:0] exp_mem [1<<AW];

  always #2.5 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .wr_n(wr_n), .lane_we_n(lane_we_n), .addr(addr), .d_in(d_in),
    .d_out(d_out), .d_oe(d_oe), .out_en_n(out_en_n), .sleep(sleep),
    .pipe_mode(pipe_mode));

  function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                        input logic [LN-1:0] en);
    logic [DW-1:0] r;
    r = o;
    for (int k = 0; k < LN; k++)
      if (en[k]) r[k*LW +: LW] = n[k*LW +: LW];
    return r;
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  // sel = {sel_a_n, sel_b_n, sel_c}; 3'b001 selects
  task automatic tick(input logic en_n, input logic [2:0] sel, input logic w_n,
                      input logic [LN-1:0] m_n, input logic [AW-1:0] a, input logic [DW-1:0] din);
    @(negedge clk);
    clk_en_n = en_n;
    {sel_a_n, sel_b_n, sel_c} = sel;
    wr_n = w_n; lane_we_n = m_n; addr = a; d_in = din;
    @(posedge clk);
    #1;
  endtask

  task automatic nop(input logic [DW-1:0] din);
    tick(1'b0, 3'b111, 1'b1, '1, '0, din);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] m_n);
    tick(1'b0, 3'b001, 1'b0, m_n, a, '0);
  endtask
  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] din);
    tick(1'b0, 3'b001, 1'b1, '1, a, din);
  endtask
  task automatic set_mode(input logic p);
    nop('0); nop('0); nop('0);
    pipe_mode = p;
    nop('0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R11 oe in reset", d_oe, 0);
    @(negedge clk) rst_n = 1'b1;
    nop('0);
    chk("R11 oe after reset", d_oe, 0);
  endtask

  task automatic t_flow_basic;
    set_mode(1'b0);
    wr(3, 2'b00);
    chk("R10 oe off in write slot", d_oe, 0);
    nop(18'h2A5A5);
    exp_mem[3] = 18'h2A5A5;
    rd(3, '0);
    chk("R2 flow oe", d_oe, 1);
    chk("R2 flow data", d_out, exp_mem[3]);
    nop('0);
    chk("R10 oe off after deselect", d_oe, 0);
  endtask

  task automatic t_pipe_basic;
    set_mode(1'b1);
    wr(5, 2'b00); nop('0); nop(18'h1C3C3);
    exp_mem[5] = 18'h1C3C3;
    wr(7, 2'b00); nop('0); nop(18'h0F0F0);
    exp_mem[7] = 18'h0F0F0;
    rd(5, '0);
    chk("R3 pipe oe not yet", d_oe, 0);
    nop('0);
    chk("R3 pipe oe", d_oe, 1);
    chk("R3 pipe data", d_out, exp_mem[5]);
    nop('0);
    chk("R10 pipe oe off", d_oe, 0);
  endtask

  task automatic t_pipe_fwd;
    logic [DW-1:0] nw;
    set_mode(1'b1);
    wr(2, 2'b00); nop('0); nop(18'h12345);
    exp_mem[2] = 18'h12345;
    nw = 18'h3FFFF;
    wr(2, 2'b10);
    rd(2, '0);
    chk("R10 oe off in write slot", d_oe, 0);
    rd(7, nw);
    exp_mem[2] = mrg(exp_mem[2], nw, 2'b01);
    chk("R6 rwr oe", d_oe, 1);
    chk("R5 forwarded merge", d_out, exp_mem[2]);
    nop('0);
    chk("R6 read after write", d_out, exp_mem[7]);
    rd(2, '0); nop('0);
    chk("R5 array holds merge", d_out, exp_mem[2]);
  endtask

  task automatic t_flow_rwr;
    set_mode(1'b0);
    rd(3, '0);
    chk("R6 flow first read", d_out, exp_mem[3]);
    wr(4, 2'b00);
    chk("R10 flow write slot oe", d_oe, 0);
    rd(7, 18'h15A5A);
    exp_mem[4] = 18'h15A5A;
    chk("R6 flow read after write", d_out, exp_mem[7]);
    rd(4, '0);
    chk("R2 flow late write data", d_out, exp_mem[4]);
  endtask

  task automatic t_mask;
    set_mode(1'b0);
    wr(4, 2'b01); nop(18'h3C0FF);
    exp_mem[4] = mrg(exp_mem[4], 18'h3C0FF, 2'b10);
    rd(4, '0);
    chk("R4 upper lane only", d_out, exp_mem[4]);
    wr(4, 2'b11); nop(18'h00000);
    rd(4, '0);
    chk("R4 no lanes enabled", d_out, exp_mem[4]);
  endtask

  task automatic t_stall;
    set_mode(1'b1);
    rd(5, '0);
    tick(1'b1, 3'b001, 1'b0, 2'b00, 5, 18'h3FFFF);
    chk("R7 stall holds oe", d_oe, 0);
    nop('0);
    chk("R7 read after stall", d_out, exp_mem[5]);
    wr(6, 2'b00);
    tick(1'b1, 3'b111, 1'b1, '1, 0, 18'h11111);
    nop(18'h22222);
    nop(18'h0ABCD);
    exp_mem[6] = 18'h0ABCD;
    rd(6, '0); nop('0);
    chk("R7 pending write held", d_out, exp_mem[6]);
  endtask

  task automatic t_select;
    logic [2:0] bad [3];
    set_mode(1'b0);
    bad[0] = 3'b101; bad[1] = 3'b011; bad[2] = 3'b000;
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, bad[i], 1'b0, 2'b00, 3, '0);
      nop(18'h3DEAD);
      tick(1'b0, bad[i], 1'b1, '1, 3, '0);
      chk("R1 bad select read oe", d_oe, 0);
      rd(3, '0);
      chk("R1 bad select write ignored", d_out, exp_mem[3]);
    end
  endtask

  task automatic t_oe;
    set_mode(1'b0);
    rd(3, '0);
    out_en_n = 1'b1;
    #0.5 chk("R8 async oe off", d_oe, 0);
    out_en_n = 1'b0;
    #0.5 chk("R8 oe back", d_oe, 1);
    chk("R8 data back", d_out, exp_mem[3]);
  endtask

  task automatic t_sleep;
    set_mode(1'b0);
    rd(3, '0);
    sleep = 1'b1;
    #0.5 chk("R9 sleep oe off", d_oe, 0);
    wr(3, 2'b00);
    nop(18'h0BEEF);
    rd(3, '0);
    chk("R9 read in sleep", d_oe, 0);
    @(negedge clk) sleep = 1'b0;
    rd(3, '0);
    chk("R9 write in sleep ignored", d_out, exp_mem[3]);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) exp_mem[i] = '0;
    t_reset();
    t_flow_basic();
    t_pipe_basic();
    t_pipe_fwd();
    t_flow_rwr();
    t_mask();
    t_stall();
    t_select();
    t_oe();
    t_sleep();
    finish_run();
  end
endmodule